// File: doc/BRIEF.md
# Window Watchdog Reset Supervisor

This block drives an active-low system reset from two asynchronous inputs: a supply-good flag from an external voltage comparator and a watchdog kick from the supervised processor. Reset is held while the supply is bad. When the supply comes back, or after a watchdog fault, reset is stretched for a configurable delay and then released.

After release the block times the rising edges of the kick input. The first window after any release is open: it accepts a kick at any time up to the upper bound. Every accepted kick starts a new window. That window has a closed front part, and a kick inside it counts as a fault. A missing kick also counts as a fault. A status output records why reset was last asserted.

Window bounds and the reset delay are counted in clock cycles. They are captured only while reset is asserted, so a window in progress always runs on the values it started with.

Top module: `wwdg_supervisor`

## Requirements
- R1: While the synchronized supply-good is low, sysResetN is low. A drop of supplyOkAsync pulls sysResetN low on the third rising clock edge after the drop. If the drop happens while reset is released or stretching, faultCause becomes 1.
- R2: After supplyOkAsync rises and stays high, sysResetN rises on rising edge number cfgResetDelay+3 after the rise: two edges through the synchronizer, one entry edge, then cfgResetDelay edges of stretch.
- R3: In the first window after a release, a kick is accepted no matter how soon it comes after the release. sysResetN stays high, and the accepted kick opens a bounded window.
- R4: The edge at which sysResetN rises, or at which a kick is accepted, is edge 0 of a window. A kick on kickAsync acts two edges after it is first sampled. In a bounded window, a kick acting at edge n with cfgLowerBound < n <= cfgUpperBound is accepted.
- R5: In a bounded window, a kick acting at edge n <= cfgLowerBound drives sysResetN low at that edge and sets faultCause to 2.
- R6: If no kick is accepted by edge cfgUpperBound of any window, sysResetN goes low at that edge and faultCause becomes 3. A kick acting at that same edge still counts as accepted.
- R7: After a watchdog fault at edge F, sysResetN rises again at edge F+cfgResetDelay. faultCause returns to 0 at the release, and the new window is an open first window.
- R8: The configuration inputs are captured only while sysResetN is low. Changes made while reset is released take effect only after the next reset.
- R9: faultCause encoding: 0 means no fault since the last release or since power-on reset, 1 means supply, 2 means early kick, 3 means late kick. The value holds from the fault until the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset of the logic, active low |
| supplyOkAsync | input | 1 | Supply-good flag from the comparator, asynchronous |
| kickAsync | input | 1 | Watchdog kick from the processor, asynchronous; rising edges count |
| cfgResetDelay | input | CNT_W | Reset stretch length in cycles |
| cfgLowerBound | input | CNT_W | Closed part of a bounded window in cycles |
| cfgUpperBound | input | CNT_W | Window timeout in cycles |
| sysResetN | output | 1 | System reset, active low |
| faultCause | output | 2 | Cause of the current or last reset (see R9) |

## Verification
A wrong state in the monitor shows up at the ports very quickly. If the block loses track of whether the current window is open or bounded, a kick right after release drops sysResetN on the acting edge. If a window counter is off, the early or late fault lands one edge away from its computed edge, and sysResetN shows that within a single cycle. If configuration is captured while reset is released, a window in progress times out at the new bound instead of the old one, and the error is visible before the next kick.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_SUPPLY = 2'd1,
    CAUSE_EARLY  = 2'd2,
    CAUSE_LATE   = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_DELAY  = 2'd1,
    ST_OPEN   = 2'd2,
    ST_BOUND  = 2'd3
  } state_e;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic cfgLoad;
  } strobes_t;

endpackage

// File: rtl/wwdg_datapath.sv
module wwdg_datapath
  import wwdg_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supplyOkAsync,
  input  logic             kickAsync,
  input  logic [CNT_W-1:0] cfgResetDelay,
  input  logic [CNT_W-1:0] cfgLowerBound,
  input  logic [CNT_W-1:0] cfgUpperBound,
  input  strobes_t         strb,
  output logic             supplyOk,
  output logic             kickRise,
  output logic             delayDone,
  output logic             belowLower,
  output logic             atUpper
);

  localparam int EXT_W = CNT_W + 1;

  logic [SYNC_STAGES-1:0] supplySh;
  logic [SYNC_STAGES-1:0] kickSh;
  logic                   kickPrev;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-1:0]       delayLat;
  logic [CNT_W-1:0]       lowerLat;
  logic [CNT_W-1:0]       upperLat;
  logic [EXT_W-1:0]       cntNext;

  // Synchronizer chains, one stage per generate iteration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      supplySh[0] <= 1'b0;
      kickSh[0]   <= 1'b0;
    end else begin
      supplySh[0] <= supplyOkAsync;
      kickSh[0]   <= kickAsync;
    end
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        supplySh[g] <= 1'b0;
        kickSh[g]   <= 1'b0;
      end else begin
        supplySh[g] <= supplySh[g-1];
        kickSh[g]   <= kickSh[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kickPrev <= 1'b0;
    else        kickPrev <= kickSh[SYNC_STAGES-1];
  end

  assign supplyOk = supplySh[SYNC_STAGES-1];
  assign kickRise = kickSh[SYNC_STAGES-1] & ~kickPrev;

  // Configuration capture, only on request of the control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delayLat <= '0;
      lowerLat <= '0;
      upperLat <= '0;
    end else if (strb.cfgLoad) begin
      delayLat <= cfgResetDelay;
      lowerLat <= cfgLowerBound;
      upperLat <= cfgUpperBound;
    end
  end

  // Shared window / delay counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (strb.cntClear) cnt <= '0;
    else if (strb.cntInc)   cnt <= cntNext[CNT_W-1:0];
  end

  assign cntNext    = {1'b0, cnt} + EXT_W'(1);
  assign delayDone  = cntNext >= {1'b0, delayLat};
  assign atUpper    = cntNext >= {1'b0, upperLat};
  assign belowLower = cnt < lowerLat;

  // R8: captured bounds never move while the control is not loading them
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.cfgLoad && $past(!strb.cfgLoad)) |-> ($stable(upperLat) && $stable(lowerLat)))
    else $error("R8: configuration changed outside reset");

endmodule

// File: rtl/wwdg_control.sv
module wwdg_control
  import wwdg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     supplyOk,
  input  logic     kickRise,
  input  logic     delayDone,
  input  logic     belowLower,
  input  logic     atUpper,
  output strobes_t strb,
  output logic     sysResetN,
  output cause_e   cause
);

  state_e state, stateNext;
  cause_e causeNext;

  always_comb begin
    stateNext = state;
    causeNext = cause;
    strb      = '0;
    unique case (state)
      ST_HOLD: begin
        strb.cfgLoad  = 1'b1;
        strb.cntClear = 1'b1;
        if (supplyOk) stateNext = ST_DELAY;
      end
      ST_DELAY: begin
        strb.cfgLoad = 1'b1;
        if (!supplyOk) begin
          stateNext     = ST_HOLD;
          causeNext     = CAUSE_SUPPLY;
          strb.cntClear = 1'b1;
        end else if (delayDone) begin
          stateNext     = ST_OPEN;
          causeNext     = CAUSE_NONE;
          strb.cntClear = 1'b1;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      ST_OPEN, ST_BOUND: begin
        if (!supplyOk) begin
          stateNext     = ST_HOLD;
          causeNext     = CAUSE_SUPPLY;
          strb.cntClear = 1'b1;
        end else if (kickRise) begin
          strb.cntClear = 1'b1;
          if (state == ST_BOUND && belowLower) begin
            stateNext = ST_DELAY;
            causeNext = CAUSE_EARLY;
          end else begin
            stateNext = ST_BOUND;
          end
        end else if (atUpper) begin
          stateNext     = ST_DELAY;
          causeNext     = CAUSE_LATE;
          strb.cntClear = 1'b1;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      default: stateNext = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HOLD;
      cause <= CAUSE_NONE;
    end else begin
      state <= stateNext;
      cause <= causeNext;
    end
  end

  assign sysResetN = (state == ST_OPEN) || (state == ST_BOUND);

  // R1: a bad supply always yields reset on the next cycle
  a_r1_supply_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !supplyOk |=> !sysResetN)
    else $error("R1: reset released with supply bad");

  // R3: the open window takes any kick
  a_r3_open_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OPEN && supplyOk && kickRise) |=> (sysResetN && state == ST_BOUND))
    else $error("R3: kick in open window not accepted");

  // R5: early kick in a bounded window
  a_r5_early_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BOUND && supplyOk && kickRise && belowLower)
      |=> (!sysResetN && cause == CAUSE_EARLY))
    else $error("R5: early kick missed");

  // R6: timeout
  a_r6_late_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (sysResetN && supplyOk && !kickRise && atUpper)
      |=> (!sysResetN && cause == CAUSE_LATE))
    else $error("R6: timeout missed");

  // R7: release always clears the recorded cause
  a_r7_release_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysResetN) |-> (cause == CAUSE_NONE))
    else $error("R7: cause not cleared on release");

endmodule

// File: rtl/wwdg_supervisor.sv
module wwdg_supervisor
  import wwdg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supplyOkAsync,
  input  logic             kickAsync,
  input  logic [CNT_W-1:0] cfgResetDelay,
  input  logic [CNT_W-1:0] cfgLowerBound,
  input  logic [CNT_W-1:0] cfgUpperBound,
  output logic             sysResetN,
  output logic [1:0]       faultCause
);

  localparam int SYNC_STAGES = 2;

  strobes_t strb;
  logic     supplyOk;
  logic     kickRise;
  logic     delayDone;
  logic     belowLower;
  logic     atUpper;
  cause_e   cause;

  wwdg_datapath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk          (clk),
    .rst_n        (rst_n),
    .supplyOkAsync(supplyOkAsync),
    .kickAsync    (kickAsync),
    .cfgResetDelay(cfgResetDelay),
    .cfgLowerBound(cfgLowerBound),
    .cfgUpperBound(cfgUpperBound),
    .strb         (strb),
    .supplyOk     (supplyOk),
    .kickRise     (kickRise),
    .delayDone    (delayDone),
    .belowLower   (belowLower),
    .atUpper      (atUpper)
  );

  wwdg_control i_control (
    .clk       (clk),
    .rst_n     (rst_n),
    .supplyOk  (supplyOk),
    .kickRise  (kickRise),
    .delayDone (delayDone),
    .belowLower(belowLower),
    .atUpper   (atUpper),
    .strb      (strb),
    .sysResetN (sysResetN),
    .cause     (cause)
  );

  assign faultCause = cause;

endmodule

// File: tb/test_wwdg_supervisor.sv
module test_wwdg_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             supplyOkAsync = 1'b0;
  logic             kickAsync = 1'b0;
  logic [CNT_W-1:0] cfgResetDelay = 16'd5;
  logic [CNT_W-1:0] cfgLowerBound = 16'd4;
  logic [CNT_W-1:0] cfgUpperBound = 16'd12;
  logic             sysResetN;
  logic [1:0]       faultCause;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wwdg_supervisor #(.CNT_W(CNT_W)) i_wwdg_supervisor (
    .clk          (clk),
    .rst_n        (rst_n),
    .supplyOkAsync(supplyOkAsync),
    .kickAsync    (kickAsync),
    .cfgResetDelay(cfgResetDelay),
    .cfgLowerBound(cfgLowerBound),
    .cfgUpperBound(cfgUpperBound),
    .sysResetN    (sysResetN),
    .faultCause   (faultCause)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Edges until sysResetN reaches the given level
  task automatic waitLevel(input logic lvl, output int n);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      tick(1);
      n++;
      if (sysResetN == lvl) break;
    end
  endtask

  // Called at edge 0 of a window; returns at edge n where the kick acts (n >= 3)
  task automatic kickAt(input int n);
    if (n > 3) tick(n - 3);
    kickAsync = 1'b1;
    tick(2);
    kickAsync = 1'b0;
    tick(1);
  endtask

  task automatic testResetState();
    tick(3);
    checkEq("R1", "sysResetN in reset", sysResetN, 0);
    checkEq("R9", "cause in reset", faultCause, 0);
    rst_n = 1'b1;
    tick(20);
    checkEq("R1", "held with supply bad", sysResetN, 0);
  endtask

  task automatic testPowerUp();
    int n;
    supplyOkAsync = 1'b1;
    waitLevel(1'b1, n);
    checkEq("R2", "edges to release", n, 8);
    checkEq("R9", "cause after release", faultCause, 0);
  endtask

  task automatic testWindows();
    int n;
    kickAt(3);
    checkEq("R3", "early kick in open window", sysResetN, 1);
    kickAt(5);
    checkEq("R4", "kick just past lower bound", sysResetN, 1);
    kickAt(12);
    checkEq("R4", "kick at upper bound", sysResetN, 1);
    kickAt(4);
    checkEq("R5", "kick at lower bound", sysResetN, 0);
    checkEq("R5", "early cause", faultCause, 2);
    waitLevel(1'b1, n);
    checkEq("R7", "stretch after early fault", n, 5);
    checkEq("R7", "cause cleared", faultCause, 0);
    waitLevel(1'b0, n);
    checkEq("R6", "timeout in open window", n, 12);
    checkEq("R6", "late cause", faultCause, 3);
    waitLevel(1'b1, n);
    checkEq("R7", "stretch after late fault", n, 5);
  endtask

  task automatic testLateBoundary();
    int n;
    kickAt(3);
    tick(10);
    kickAsync = 1'b1;
    tick(2);
    checkEq("R6", "kick one edge after timeout", sysResetN, 0);
    checkEq("R6", "late cause at boundary", faultCause, 3);
    kickAsync = 1'b0;
    waitLevel(1'b1, n);
    checkEq("R7", "stretch after boundary fault", n, 5);
  endtask

  task automatic testConfig();
    int n;
    cfgUpperBound = 16'd30;
    cfgLowerBound = 16'd6;
    waitLevel(1'b0, n);
    checkEq("R8", "running window keeps old bound", n, 12);
    waitLevel(1'b1, n);
    waitLevel(1'b0, n);
    checkEq("R8", "new upper bound after reset", n, 30);
    waitLevel(1'b1, n);
    kickAt(3);
    kickAt(6);
    checkEq("R8", "new lower bound catches early kick", sysResetN, 0);
    checkEq("R5", "early cause with new bound", faultCause, 2);
    cfgUpperBound = 16'd12;
    cfgLowerBound = 16'd4;
    waitLevel(1'b1, n);
    checkEq("R7", "release after reconfig", n, 5);
  endtask

  task automatic testBrownout();
    int n;
    kickAt(3);
    supplyOkAsync = 1'b0;
    tick(2);
    checkEq("R1", "synchronizer latency", sysResetN, 1);
    tick(1);
    checkEq("R1", "reset on brownout", sysResetN, 0);
    checkEq("R9", "supply cause", faultCause, 1);
    tick(10);
    checkEq("R1", "held during brownout", sysResetN, 0);
    cfgResetDelay = 16'd9;
    supplyOkAsync = 1'b1;
    waitLevel(1'b1, n);
    checkEq("R2", "release with new delay", n, 12);
    checkEq("R9", "cause cleared after brownout", faultCause, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    testResetState();
    testPowerUp();
    testWindows();
    testLateBoundary();
    testConfig();
    testBrownout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule